// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block produces the internal reset controls of a small 8-bit microcontroller from three sources. They are an active-low external reset pin, a single-cycle watchdog timeout pulse and a single-cycle stop-mode recovery pulse. The pin is asynchronous. It passes through a two-flop synchronizer, and a low-time counter must then qualify it before it can cause a reset. Once a reset is entered, the core is held until a fixed release count expires. A one-cycle fetch-start pulse then tells the core to begin executing.

Every reset entry pulses a program-counter load that carries the fixed reset vector. Only a pin reset also pulses the default-load strobe for the control and port registers. That strobe goes with a next-value bus: each bit is forced to 1, forced to 0 or kept, according to two mask parameters. Watchdog and stop-mode resets only re-vector the core and leave those registers alone. No output of the block ever clears the general-purpose register file. A sticky cause register reports which source produced the most recent reset.

A separate power-on input `por_n` initialises the sequencer itself. It leaves the core held, and the core is then released through the normal release count.

Top module: `rst_seq`

## Requirements
- R1: The pin is sampled through two flops, and a reset is entered only after the synchronized pin has been low for LOW_CYCLES (30) consecutive clock edges. Suppose the pin is driven low just after edge c and stays low. Then `core_hold` rises and `pc_load` pulses on edge c+32.
- R2: A low period of 29 edges or fewer causes no reset. Any high sample restarts the low-time count, so two such pulses separated by a short high period also cause no reset.
- R3: The low-time counter saturates. A pin held low for any length of time keeps `core_hold` high and produces exactly one reset entry, with no fetch-start while the pin stays low.
- R4: Suppose the pin returns high just after edge d, following a qualified pin reset. Then `core_hold` falls and `fetch_start` pulses for one cycle on edge d+12, which is RELEASE_CYCLES (10) edges after the synchronized pin is seen high.
- R5: Suppose a watchdog or stop-mode pulse is sampled on edge c. Then `core_hold` is high from edge c, and `fetch_start` pulses for one cycle on edge c+10 as `core_hold` falls. No low-time qualification applies.
- R6: Every reset entry pulses `pc_load` for one cycle while `core_hold` is high, and `pc_vector` is 0x0020.
- R7: `ctrl_load` pulses only on a pin reset entry, never for a watchdog or stop-mode reset. `ctrl_next` equals (`ctrl_cur` AND NOT CTRL_CLR) OR CTRL_SET. With the defaults, bits 7 and 0 are forced to 1, bits 5 and 4 are forced to 0, and the rest are kept.
- R8: `cause` is sticky until the next reset entry, with the encoding 00 none (power-on), 01 pin, 10 watchdog, 11 stop-mode. A pin qualification that arrives on the same edge as a watchdog pulse wins.
- R9: When watchdog and stop-mode pulses arrive on the same edge, the cause is 10 (watchdog).
- R10: While `por_n` is low, `core_hold` is 1, `cause` is 00, and `pc_load`, `ctrl_load` and `fetch_start` are 0. Suppose `por_n` rises just after edge c. Then `fetch_start` pulses on edge c+10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| por_n | input | 1 | Power-on initialisation of the sequencer, active low, asynchronous |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_pulse | input | 1 | Watchdog timeout, one-cycle pulse |
| smr_pulse | input | 1 | Stop-mode recovery, one-cycle pulse |
| ctrl_cur | input | CTRL_W | Current control/port register value |
| core_hold | output | 1 | Holds the CPU core in reset |
| pc_load | output | 1 | One-cycle program-counter load |
| pc_vector | output | 16 | Reset vector, 0x0020 |
| ctrl_load | output | 1 | One-cycle control/port default-load strobe (pin reset only) |
| ctrl_next | output | CTRL_W | Masked default value for the control/port registers |
| fetch_start | output | 1 | One-cycle pulse when the core is released |
| cause | output | 2 | Sticky cause of the last reset |

## Verification
A pin reset enters on the 32nd edge after the pin falls: two synchronizer edges plus thirty counted samples. It releases on the 12th edge after the pin rises. A watchdog or stop-mode entry appears on the sampling edge itself, and its release comes ten edges later. The bench drives every stimulus just after a falling edge and notes the edge count at that moment. From it the bench computes the exact edge of each entry and release pulse and queues those edges as expected events. A monitor then compares each observed pulse at the following falling edge against the head of the queue. Any pulse that arrives early, arrives late or is not expected is reported against its requirement.

// File: rtl/rst_seq.sv
module rst_seq #(
  parameter int LOW_CYCLES     = 30,
  parameter int RELEASE_CYCLES = 10,
  parameter logic [15:0] VECTOR = 16'h0020,
  parameter int CTRL_W = 8,
  parameter logic [CTRL_W-1:0] CTRL_SET = 'h81,
  parameter logic [CTRL_W-1:0] CTRL_CLR = 'h30
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_pin_n,
  input  logic              wdt_pulse,
  input  logic              smr_pulse,
  input  logic [CTRL_W-1:0] ctrl_cur,
  output logic              core_hold,
  output logic              pc_load,
  output logic [15:0]       pc_vector,
  output logic              ctrl_load,
  output logic [CTRL_W-1:0] ctrl_next,
  output logic              fetch_start,
  output logic [1:0]        cause
);
  localparam int LW = $clog2(LOW_CYCLES + 1);
  localparam int RW = $clog2(RELEASE_CYCLES + 1);
  localparam logic [1:0] C_PIN = 2'b01, C_WDT = 2'b10, C_SMR = 2'b11;

  logic [1:0]    sync;
  logic [LW-1:0] low_cnt;
  logic [RW-1:0] rel_cnt;
  logic          pin_wait;

  wire pin_lo  = !sync[1];
  wire pin_hit = pin_lo && (low_cnt == LW'(LOW_CYCLES - 1));

  assign pc_vector = VECTOR;
  assign ctrl_next = (ctrl_cur & ~CTRL_CLR) | CTRL_SET;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sync        <= 2'b11;
      low_cnt     <= '0;
      rel_cnt     <= RW'(RELEASE_CYCLES);
      pin_wait    <= 1'b0;
      core_hold   <= 1'b1;
      cause       <= 2'b00;
      pc_load     <= 1'b0;
      ctrl_load   <= 1'b0;
      fetch_start <= 1'b0;
    end else begin
      sync        <= {sync[0], rst_pin_n};
      pc_load     <= 1'b0;
      ctrl_load   <= 1'b0;
      fetch_start <= 1'b0;
      if (!pin_lo)
        low_cnt <= '0;
      else if (low_cnt != LW'(LOW_CYCLES))
        low_cnt <= low_cnt + 1'b1;

      if (pin_hit) begin
        core_hold <= 1'b1;
        pin_wait  <= 1'b1;
        rel_cnt   <= '0;
        cause     <= C_PIN;
        pc_load   <= 1'b1;
        ctrl_load <= 1'b1;
      end else if (pin_wait) begin
        if (!pin_lo) begin
          pin_wait <= 1'b0;
          rel_cnt  <= RW'(RELEASE_CYCLES - 1);
        end
      end else if (wdt_pulse || smr_pulse) begin
        core_hold <= 1'b1;
        rel_cnt   <= RW'(RELEASE_CYCLES);
        cause     <= wdt_pulse ? C_WDT : C_SMR;
        pc_load   <= 1'b1;
      end else if (core_hold && rel_cnt != '0) begin
        rel_cnt <= rel_cnt - 1'b1;
        if (rel_cnt == RW'(1)) begin
          core_hold   <= 1'b0;
          fetch_start <= 1'b1;
        end
      end
    end
  end

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!por_n) low_cnt <= LW'(LOW_CYCLES)); // R3
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!por_n) pin_wait |-> core_hold); // R3
  AST_ENTRY_LOADS_PC: assert property (@(posedge clk) disable iff (!por_n) $rose(core_hold) |-> pc_load); // R6
  AST_LOAD_WHILE_HELD: assert property (@(posedge clk) disable iff (!por_n) pc_load |-> core_hold); // R6
  AST_CTRL_PIN_ONLY: assert property (@(posedge clk) disable iff (!por_n) ctrl_load |-> (cause == C_PIN)); // R7
  AST_FETCH_AT_RELEASE: assert property (@(posedge clk) disable iff (!por_n) fetch_start |-> (!core_hold && $past(core_hold))); // R5
  AST_FETCH_SINGLE: assert property (@(posedge clk) disable iff (!por_n) fetch_start |=> !fetch_start); // R4
endmodule

// File: tb/rst_seq_tb_top.sv
module rst_seq_tb_top;
  localparam time CLK_P = 20ns;
  localparam logic [7:0] SET_M = 8'h81, CLR_M = 8'h30;

  logic clk = 0, por_n = 0, rst_pin_n = 1, wdt_pulse = 0, smr_pulse = 0;
  logic [7:0] ctrl_cur = 8'h00;
  logic core_hold, pc_load, ctrl_load, fetch_start;
  logic [15:0] pc_vector;
  logic [7:0] ctrl_next;
  logic [1:0] cause;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  typedef struct {bit fetch; int at; logic [1:0] cz; bit ctl; string tag;} ev_t;
  ev_t q[$];

  rst_seq dut_i (.clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .wdt_pulse(wdt_pulse),
    .smr_pulse(smr_pulse), .ctrl_cur(ctrl_cur), .core_hold(core_hold), .pc_load(pc_load),
    .pc_vector(pc_vector), .ctrl_load(ctrl_load), .ctrl_next(ctrl_next),
    .fetch_start(fetch_start), .cause(cause));

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic push(bit f, int at, logic [1:0] cz, bit ctl, string tag);
    ev_t e;
    e.fetch = f; e.at = at; e.cz = cz; e.ctl = ctl; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic take(bit f);
    ev_t e;
    if (q.size() == 0) begin
      chk(0, f ? "R4/R5" : "R2/R3", f ? "unexpected fetch_start at edge" : "unexpected reset entry at edge", cyc, -1);
      return;
    end
    e = q.pop_front();
    chk(e.fetch == f, e.tag, "event kind", f, e.fetch);
    chk(e.at == cyc, e.tag, "event edge", cyc, e.at);
    if (!f) begin
      chk(cause == e.cz, e.tag, "cause", cause, e.cz);
      chk(ctrl_load == e.ctl, e.tag, "ctrl_load", ctrl_load, e.ctl);
      chk(core_hold && pc_vector == 16'h0020, "R6", "hold/vector at entry", pc_vector, 16'h0020);
    end else begin
      chk(!core_hold, e.tag, "core_hold at fetch", core_hold, 0);
    end
  endtask

  always @(negedge clk) if (por_n) begin
    if (pc_load) take(0);
    if (fetch_start) take(1);
  end

  task automatic drain(int n, string tag);
    repeat (n) @(negedge clk);
    chk(q.size() == 0, tag, "pending expected events", q.size(), 0);
  endtask

  task automatic pin_low(int len, bit qual, string tag);
    int c;
    c = cyc;
    rst_pin_n = 0;
    if (qual) push(0, c + 32, 2'b01, 1, tag);
    repeat (len) @(negedge clk);
    rst_pin_n = 1;
    if (qual) push(1, cyc + 12, 2'b00, 0, "R4");
  endtask

  task automatic pulse(bit w, bit s, logic [1:0] cz, string tag);
    wdt_pulse = w; smr_pulse = s;
    push(0, cyc + 1, cz, 0, tag);
    push(1, cyc + 11, 2'b00, 0, "R5");
    @(negedge clk);
    wdt_pulse = 0; smr_pulse = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(core_hold == 1, "R10", "core_hold in power-on", core_hold, 1);
    chk(cause == 2'b00, "R10", "cause in power-on", cause, 0);
    chk(!pc_load && !ctrl_load && !fetch_start, "R10", "pulses in power-on", {pc_load, ctrl_load, fetch_start}, 0);
    por_n = 1;
    push(1, cyc + 10, 2'b00, 0, "R10");
    drain(15, "R10");

    // R7 mask behaviour
    ctrl_cur = 8'h5A; #1;
    chk(ctrl_next == ((8'h5A & ~CLR_M) | SET_M), "R7", "ctrl_next 0x5A", ctrl_next, 8'hCB);
    ctrl_cur = 8'h30; #1;
    chk(ctrl_next == 8'h81, "R7", "ctrl_next 0x30", ctrl_next, 8'h81);
    ctrl_cur = 8'hFF; #1;
    chk(ctrl_next == 8'hCF, "R7", "ctrl_next 0xFF", ctrl_next, 8'hCF);
    @(negedge clk);

    // R1, R4 qualified pin reset of exactly 30 edges
    pin_low(30, 1, "R1");
    drain(20, "R1");
    chk(cause == 2'b01, "R8", "cause sticky after pin", cause, 1);

    // R2 short pulses restart the count
    pin_low(29, 0, "R2");
    repeat (2) @(negedge clk);
    pin_low(29, 0, "R2");
    drain(40, "R2");
    chk(core_hold == 0, "R2", "no hold after short pulses", core_hold, 0);

    // R5 watchdog and stop-mode
    pulse(1, 0, 2'b10, "R5");
    drain(15, "R5");
    chk(cause == 2'b10, "R8", "cause sticky after watchdog", cause, 2);
    pulse(0, 1, 2'b11, "R7");
    drain(15, "R7");
    chk(cause == 2'b11, "R8", "cause after stop-mode", cause, 3);

    // R9 watchdog beats stop-mode
    pulse(1, 1, 2'b10, "R9");
    drain(15, "R9");

    // R3 long low, counter saturates
    begin
      int c;
      c = cyc;
      rst_pin_n = 0;
      push(0, c + 32, 2'b01, 1, "R3");
      repeat (150) @(negedge clk);
      chk(core_hold == 1, "R3", "core_hold during long low", core_hold, 1);
      chk(q.size() == 0, "R3", "single entry during long low", q.size(), 0);
      rst_pin_n = 1;
      push(1, cyc + 12, 2'b00, 0, "R4");
      drain(20, "R3");
    end

    // R8 pin wins over watchdog on the qualifying edge
    begin
      int c;
      c = cyc;
      rst_pin_n = 0;
      push(0, c + 32, 2'b01, 1, "R8");
      repeat (31) @(negedge clk);
      wdt_pulse = 1;
      @(negedge clk);
      wdt_pulse = 0;
      repeat (8) @(negedge clk);
      rst_pin_n = 1;
      push(1, cyc + 12, 2'b00, 0, "R8");
      drain(20, "R8");
      chk(cause == 2'b01, "R8", "cause after simultaneous sources", cause, 1);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule